// File: doc/BRIEF.md
# Thirty-two pin GPIO controller with edge interrupts

This block gives software control over 32 general-purpose pins through six word-wide registers on a simple register bus. A write strobe, a read strobe, an address and an access-size code qualify each transfer. Each pin is set as an input or an output by its direction bit. Output pins are driven from the data register. Input pins pass through a two-stage synchronizer, and the synchronized level is sampled into the data register.

A per-pin edge detector records transitions on input pins in a sticky event register. A control bit on each pin picks between two capture modes: any level change, or only high-to-low transitions. Software clears event bits by writing ones to them. The single level interrupt output is high while any event bit is also enabled in the mask register. The open-drain register has no effect inside the block. Its value is only exported to the pad logic.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset all six registers read as zero, no pin is an output (`pin_oe` all zero) and `irq` is low.
- R2: The registers sit at these byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, control 0x14. A read registers its result, so `bus_rdata` is valid in the cycle after the clock edge that samples `bus_rd`. Any other offset reads as zero.
- R3: Pin n maps to register bit 31−n in every register. Pin 0 is the most significant bit. The vectors `pin_in`, `pin_out`, `pin_oe` and `od_ctrl` are indexed by pin number.
- R4: Only accesses with `bus_size` = 2'b10 (a 32-bit word) take effect. A narrower write changes nothing, and a narrower read returns zero.
- R5: A direction bit of 1 makes the pin an output: `pin_oe` is high and `pin_out` carries the data bit. A data write updates only the bits of output pins.
- R6: The data bit of an input pin shows the pin level three clock edges after the pin changes. A read of the data register returns the output bits merged with the sampled input bits.
- R7: With its control bit at 0, an input pin sets its event bit on any change of level.
- R8: With its control bit at 1, an input pin sets its event bit only on a high-to-low transition.
- R9: Writing the event register clears each bit written as 1. Bits written as 0 keep their value.
- R10: If an edge sets an event bit in the same clock in which a write clears it, the bit stays set.
- R11: `irq` is high exactly when the event register ANDed with the mask register is nonzero. It follows register writes on the next edge, and pin edges three edges after the pin changes.
- R12: The open-drain register appears on `od_ctrl` and affects neither the pins nor the interrupt.
- R13: Level changes on output pins set no event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | External pin levels, indexed by pin |
| pin_out | output | 32 | Output levels, indexed by pin |
| pin_oe | output | 32 | Output enables, indexed by pin |
| od_ctrl | output | 32 | Open-drain settings for pad logic, indexed by pin |
| irq | output | 1 | Level interrupt |

## Verification
The effects of a register write are due at the edge that samples the write. The bench therefore checks `irq`, `pin_out`, `pin_oe` and `od_ctrl` at the falling edge just after that edge. Read data is due one edge after the read strobe. The monitor compares the queued expectation at the falling edge after the sampling edge. A pin change reaches the data register, the event register and `irq` on the third rising edge. The bench checks `irq` low after two edges and high after three, and waits four edges before reading pin-driven state back.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe,
  output logic [31:0]       od_ctrl,
  output logic              irq
);
  localparam int NPIN = 32;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [ADDR_W-1:0] OFF_DIR = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_ODR = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_DAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_EV  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_MSK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(8'h14);

  logic [NPIN-1:0] dir_q, odr_q, dat_q, ev_q, msk_q, ctl_q;
  logic [NPIN-1:0] s1_q, s2_q, s3_q, pin_bits;
  logic [NPIN-1:0] chg, fall, ev_set, clr_mask;
  logic            full, wr_ok;

  for (genvar n = 0; n < NPIN; n++) begin : g_pinmap
    assign pin_bits[NPIN-1-n] = pin_in[n];
    assign pin_out[n]         = dat_q[NPIN-1-n];
    assign pin_oe[n]          = dir_q[NPIN-1-n];
    assign od_ctrl[n]         = odr_q[NPIN-1-n];
  end

  assign full     = (bus_size == SZ_WORD);
  assign wr_ok    = bus_wr && full;
  assign chg      = s2_q ^ s3_q;
  assign fall     = s3_q & ~s2_q;
  assign ev_set   = ~dir_q & ((~ctl_q & chg) | (ctl_q & fall));
  assign clr_mask = (wr_ok && bus_addr == OFF_EV) ? bus_wdata : '0;
  assign irq      = |(ev_q & msk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_bits;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == OFF_DIR) dir_q <= bus_wdata;
      if (bus_addr == OFF_ODR) odr_q <= bus_wdata;
      if (bus_addr == OFF_MSK) msk_q <= bus_wdata;
      if (bus_addr == OFF_CTL) ctl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      ev_q  <= '0;
    end else begin
      dat_q <= (dir_q & ((wr_ok && bus_addr == OFF_DAT) ? bus_wdata : dat_q)) | (~dir_q & s2_q);
      ev_q  <= (ev_q & ~clr_mask) | ev_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (!full) bus_rdata <= '0;
      else begin
        case (bus_addr)
          OFF_DIR: bus_rdata <= dir_q;
          OFF_ODR: bus_rdata <= odr_q;
          OFF_DAT: bus_rdata <= dat_q;
          OFF_EV:  bus_rdata <= ev_q;
          OFF_MSK: bus_rdata <= msk_q;
          OFF_CTL: bus_rdata <= ctl_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  a_r4_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && !full) |-> ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(ctl_q)));

  a_r4_narrow_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && !full) |-> (bus_rdata == '0));

  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && bus_addr == OFF_EV) |-> ((ev_q & $past(bus_wdata) & ~$past(ev_set)) == '0));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((ev_q & $past(ev_set)) == $past(ev_set)));

  a_r13_no_event_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q & ~$past(ev_q) & $past(dir_q)) == '0));

  a_r5_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_ok && bus_addr == OFF_DAT) && $stable(dir_q)) |-> ((dat_q & dir_q) == ($past(dat_q) & dir_q)));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  localparam time PERIOD = 10ns;
  localparam logic [1:0] W = 2'b10;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [1:0] bus_size = W;
  logic [31:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe, od_ctrl;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0, rd_seen = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  gpio_edge_ctrl i_gpio_edge_ctrl (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_size,
    .bus_wdata, .bus_rdata, .pin_in, .pin_out, .pin_oe, .od_ctrl, .irq);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[i] = v[31-i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = W);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr = 0; bus_size = W;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag, input logic [1:0] sz = W);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; bus_size = sz;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0; bus_size = W;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    check("R1 irq after reset", irq, 0);
    check("R1 pin_oe after reset", pin_oe, 0);
    for (int a = 0; a < 24; a += 4) rd(8'(a), 0, "R1 register reset value");

    wr(8'h00, 32'hF000_0000);
    check("R3 R5 pin_oe of pins 0..3", pin_oe, 32'h0000_000F);
    rd(8'h00, 32'hF000_0000, "R2 direction readback");
    wr(8'h08, 32'hA5A5_A5A5);
    rd(8'h08, 32'hA000_0000, "R5 data write hits output bits only");
    check("R3 R5 pin_out", pin_out, rev(32'hA000_0000));

    wr(8'h04, 32'h1234_5678);
    check("R12 od_ctrl export", od_ctrl, rev(32'h1234_5678));
    check("R12 pin_out unaffected", pin_out, rev(32'hA000_0000));
    check("R12 irq unaffected", irq, 0);
    rd(8'h04, 32'h1234_5678, "R2 open-drain readback");

    wr(8'h10, 32'hFFFF_FFFF, 2'b01);
    rd(8'h10, 0, "R4 narrow write ignored");
    rd(8'h00, 0, "R4 narrow read returns zero", 2'b00);
    rd(8'h18, 0, "R2 unmapped offset reads zero");

    wr(8'h10, 32'h0040_0000);
    rd(8'h10, 32'h0040_0000, "R2 mask readback");
    @(negedge clk);
    pin_in[8] = 1; pin_in[9] = 1;
    wait_n(2);
    check("R11 irq not before third edge", irq, 0);
    wait_n(1);
    check("R11 R6 irq after third edge", irq, 1);
    rd(8'h08, 32'hA0C0_0000, "R6 R3 merged data");
    rd(8'h0C, 32'h00C0_0000, "R7 rising edges captured");

    wr(8'h0C, 32'h0080_0000);
    rd(8'h0C, 32'h0040_0000, "R9 write-one-to-clear keeps zeros");
    check("R11 irq still high", irq, 1);
    wr(8'h0C, 32'h0040_0000);
    check("R11 R9 irq drops after clear", irq, 0);

    wr(8'h14, 32'h0020_0000);
    rd(8'h14, 32'h0020_0000, "R2 control readback");
    @(negedge clk); pin_in[10] = 1;
    wait_n(4);
    rd(8'h0C, 0, "R8 rising edge ignored");
    @(negedge clk); pin_in[10] = 0;
    wait_n(4);
    rd(8'h0C, 32'h0020_0000, "R8 falling edge captured");
    @(negedge clk); pin_in[8] = 0;
    wait_n(4);
    rd(8'h0C, 32'h00A0_0000, "R7 falling edge in any-edge mode");

    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 0, "R9 clear all");
    @(negedge clk); pin_in[9] = 0;
    wait_n(1);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h0040_0000;
    @(negedge clk);
    bus_wr = 0;
    rd(8'h0C, 32'h0040_0000, "R10 event beats clear");
    check("R10 R11 irq from surviving event", irq, 1);

    wr(8'h0C, 32'hFFFF_FFFF);
    @(negedge clk); pin_in[0] = 1; pin_in[2] = 1;
    wait_n(4);
    rd(8'h0C, 0, "R13 output pin changes ignored");
    rd(8'h08, 32'hA000_0000, "R5 output bits keep written value");
    wr(8'h10, 32'hFFFF_FFFF);
    check("R11 full mask no events", irq, 0);
    wr(8'h00, 32'h0000_0000);
    check("R5 pins released", pin_oe, 0);
    wait_n(2);
    rd(8'h08, 32'hA000_0000, "R6 former outputs show pin levels");

    wait_n(3);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule